// File: doc/BRIEF.md
# Register-list replay engine

This block replays a list of register writes that software has placed in memory. Each list entry is a pair of 32-bit words: a register address and the value to write there. Software sets the first byte of the list, the last valid byte of the list (inclusive), an event source and two access flags. The engine then arms itself. When the selected event arrives, it reads the list through a 32-bit memory read port. It issues one register write per entry on a local write bus, strictly in list order. At the end of the pass it raises a sticky done flag, and that flag drives the interrupt line.

The event source is one of three: the rising edge of a vertical-sync input, the rising edge of a line-counter match input, or a manual kick written through the control port. A fourth setting, stop, disables triggering. The typical use is to build a list of register updates during a frame and have them land at the next vertical sync. This avoids tearing.

Top module: `reglist_replay_dma`

## Requirements
- R1: An entry is 8 bytes. The word at byte offset 0 holds the target register address, and the low REG_AW bits of that word are used. The word at offset 4 holds the value. Each entry produces exactly one register write of that value to that address.
- R2: The list runs from START through the inclusive last byte END. A pass processes floor((END-START+1)/8) entries. No memory read falls outside [START, END], and every read is 4-byte aligned.
- R3: Register writes appear in list order, and no two writes occur on consecutive cycles.
- R4: Trigger select is ACCESS[1:0]: 0 is stop, 1 is the vsync rising edge, 2 is the line-match rising edge, and 3 is the manual kick (writing 1 to CTRL bit 2). Events from a source that is not selected have no effect. Stop blocks every source.
- R5: One event edge starts exactly one pass. An input held high does not retrigger. Events that arrive while a pass is in progress are ignored.
- R6: If END < START+7, a trigger performs no memory reads and no register writes, but it still sets done.
- R7: Done (STATUS bit 0) is sticky and drives irq. It is cleared only by writing 1 to CTRL bit 1, or by a soft reset.
- R8: Writing 1 to CTRL bit 0 performs a soft reset. The engine returns to idle at once, the list pointer is cleared, done is cleared and no further writes are issued. STATUS bit 1 (busy) reads 0 afterwards.
- R9: START, END and the ACCESS flags are captured at the trigger. Writing them during a pass affects only the next pass.
- R10: When ACCESS bit 3 (address increment) is 1, entry k is written to the address from entry 0 plus k. The address words of the later entries are ignored.
- R11: When ACCESS bit 2 (write direction) is 0, the pass reads the whole list and sets done, but issues no register writes.
- R12: CTRL[5:4] is the write burst length and CTRL[9:8] is the read burst length. Both are loaded on every CTRL write and both read back through CTRL. After reset they are 3 and 0. They do not change the write sequence.
- R13: A memory request keeps its valid and address unchanged until ready is seen. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_en | input | 1 | Control port write strobe |
| csr_addr | input | 3 | Control register index (0 CTRL, 1 ACCESS, 2 START, 3 END, 4 STATUS) |
| csr_wdata | input | 32 | Control write data |
| csr_rdata | output | 32 | Control read data (combinational on csr_addr) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | MEM_AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| regw_valid | output | 1 | Register write strobe |
| regw_addr | output | REG_AW | Register write address |
| regw_data | output | 32 | Register write value |
| evt_vsync | input | 1 | Vertical-sync event level |
| evt_line | input | 1 | Line-match event level |
| irq | output | 1 | Done interrupt (level) |

## Verification
The assertions assume three things about the memory side. It returns exactly one response for each accepted request. That response comes no earlier than the cycle after acceptance. It sends no response while the engine is idle, except one left over from a request that a soft reset cut short. They also assume START is word-aligned. The bench responder accepts requests on a fixed stall pattern and answers each accepted request one cycle later, with only one request in flight. Every list base is word-aligned. A new trigger follows a soft reset only after many idle cycles, so a stale response can never land in a new pass.

// File: rtl/rlr_pkg.sv
// Shared types and constants for the register-list replay engine.
// Assumes a 32-bit data path; address widths are set by the users.
package rlr_pkg;

    typedef enum logic [1:0] {
        TRIG_STOP   = 2'd0,
        TRIG_VSYNC  = 2'd1,
        TRIG_LINE   = 2'd2,
        TRIG_MANUAL = 2'd3
    } trig_sel_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CHECK,
        W_REQ_A,
        W_WAIT_A,
        W_REQ_V,
        W_WAIT_V,
        W_WRITE
    } walk_state_e;

    localparam logic [2:0] CSR_CTRL   = 3'd0;
    localparam logic [2:0] CSR_ACCESS = 3'd1;
    localparam logic [2:0] CSR_START  = 3'd2;
    localparam logic [2:0] CSR_END    = 3'd3;
    localparam logic [2:0] CSR_STATUS = 3'd4;

    localparam int ENTRY_BYTES = 8;
    localparam int VALUE_OFS   = 4;
    localparam int BURST_W     = 2;

    typedef struct packed {
        trig_sel_e sel;
        logic      wr_dir;
        logic      addr_inc;
    } access_cfg_t;

endpackage

// File: rtl/rlr_csr.sv
// Control/status register file for the replay engine.
// Holds burst fields, trigger/access setup, list bounds and the sticky
// done flag. CTRL bits 0..2 are write-only action bits (soft reset, irq
// clear, manual kick) decoded straight from the write strobe.
// Assumes one write per cycle at most and reads are combinational.
module rlr_csr
    import rlr_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_en,
    input  logic [2:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              done_set_i,
    input  logic              busy_i,
    output logic              soft_rst_o,
    output logic              kick_o,
    output access_cfg_t       cfg_o,
    output logic [MEM_AW-1:0] start_o,
    output logic [MEM_AW-1:0] end_o,
    output logic              irq_o
);

    localparam logic [BURST_W-1:0] WR_BURST_RST = BURST_W'(3);
    localparam logic [BURST_W-1:0] RD_BURST_RST = BURST_W'(0);

    logic [BURST_W-1:0] wr_burst_q;
    logic [BURST_W-1:0] rd_burst_q;
    access_cfg_t        cfg_q;
    logic [MEM_AW-1:0]  start_q;
    logic [MEM_AW-1:0]  end_q;
    logic               done_q;
    logic               ctrl_wr;
    logic               irq_clr;

    // Decode action strobes from a CTRL write.
    always_comb begin
        ctrl_wr    = csr_wr_en && (csr_addr == CSR_CTRL);
        soft_rst_o = ctrl_wr && csr_wdata[0];
        irq_clr    = ctrl_wr && csr_wdata[1];
        kick_o     = ctrl_wr && csr_wdata[2];
    end

    // Configuration registers loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_burst_q <= WR_BURST_RST;
            rd_burst_q <= RD_BURST_RST;
            cfg_q      <= '{sel: TRIG_STOP, wr_dir: 1'b0, addr_inc: 1'b0};
            start_q    <= '0;
            end_q      <= '0;
        end else if (csr_wr_en) begin
            case (csr_addr)
                CSR_CTRL: begin
                    wr_burst_q <= csr_wdata[4 +: BURST_W];
                    rd_burst_q <= csr_wdata[8 +: BURST_W];
                end
                CSR_ACCESS: begin
                    cfg_q.sel      <= trig_sel_e'(csr_wdata[1:0]);
                    cfg_q.wr_dir   <= csr_wdata[2];
                    cfg_q.addr_inc <= csr_wdata[3];
                end
                CSR_START: start_q <= csr_wdata[MEM_AW-1:0];
                CSR_END:   end_q   <= csr_wdata[MEM_AW-1:0];
                default: ;
            endcase
        end
    end

    // Sticky done flag: soft reset beats set, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o) begin
            done_q <= 1'b0;
        end else if (done_set_i) begin
            done_q <= 1'b1;
        end else if (irq_clr) begin
            done_q <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            CSR_CTRL: begin
                csr_rdata[4 +: BURST_W] = wr_burst_q;
                csr_rdata[8 +: BURST_W] = rd_burst_q;
            end
            CSR_ACCESS: begin
                csr_rdata[1:0] = cfg_q.sel;
                csr_rdata[2]   = cfg_q.wr_dir;
                csr_rdata[3]   = cfg_q.addr_inc;
            end
            CSR_START:  csr_rdata[MEM_AW-1:0] = start_q;
            CSR_END:    csr_rdata[MEM_AW-1:0] = end_q;
            CSR_STATUS: begin
                csr_rdata[0] = done_q;
                csr_rdata[1] = busy_i;
            end
            default: ;
        endcase
    end

    assign cfg_o   = cfg_q;
    assign start_o = start_q;
    assign end_o   = end_q;
    assign irq_o   = done_q;

    // R7: done stays set unless cleared or soft-reset.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !irq_clr && !soft_rst_o) |=> done_q)
        else $error("done dropped without a clear");

endmodule

// File: rtl/rlr_trigger.sv
// Event front end: registers the two event inputs, detects rising edges
// and forwards the one picked by the select field as a single start pulse.
// Starts are suppressed while the walker is busy, so events during a pass
// are dropped, not queued. The manual kick is already a one-cycle pulse.
module rlr_trigger
    import rlr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_sel_e sel_i,
    input  logic      vsync_i,
    input  logic      line_i,
    input  logic      kick_i,
    input  logic      busy_i,
    output logic      fire_o
);

    logic vsync_q;
    logic line_q;
    logic vsync_rise;
    logic line_rise;
    logic picked;

    // Previous-cycle copies of the event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            vsync_q <= vsync_i;
            line_q  <= line_i;
        end
    end

    // Select the armed source and gate with the walker's busy state.
    always_comb begin
        vsync_rise = vsync_i && !vsync_q;
        line_rise  = line_i && !line_q;
        case (sel_i)
            TRIG_VSYNC:  picked = vsync_rise;
            TRIG_LINE:   picked = line_rise;
            TRIG_MANUAL: picked = kick_i;
            default:     picked = 1'b0;
        endcase
        fire_o = picked && !busy_i;
    end

endmodule

// File: rtl/rlr_walker.sv
// List walker: on a start pulse it captures the bounds and flags, then for
// each whole 8-byte entry inside [start, end] reads the address word and
// the value word and issues one register write. Done is signalled when the
// next entry would not fit. Assumes one response per accepted request,
// arriving no earlier than the following cycle, and a word-aligned start.
module rlr_walker
    import rlr_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int REG_AW = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              start_i,
    input  logic [MEM_AW-1:0] start_addr_i,
    input  logic [MEM_AW-1:0] end_addr_i,
    input  logic              wr_dir_i,
    input  logic              addr_inc_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [MEM_AW-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              regw_valid_o,
    output logic [REG_AW-1:0] regw_addr_o,
    output logic [DATA_W-1:0] regw_data_o,
    output logic              busy_o,
    output logic              done_set_o
);

    localparam logic [MEM_AW:0]   SPAN     = (MEM_AW+1)'(ENTRY_BYTES - 1);
    localparam logic [MEM_AW-1:0] STEP     = MEM_AW'(ENTRY_BYTES);
    localparam logic [MEM_AW-1:0] VAL_STEP = MEM_AW'(VALUE_OFS);

    walk_state_e       state_q;
    logic [MEM_AW-1:0] ptr_q;
    logic [MEM_AW-1:0] end_q;
    logic              wr_dir_q;
    logic              inc_q;
    logic              first_q;
    logic [REG_AW-1:0] addr_word_q;
    logic [REG_AW-1:0] prev_addr_q;
    logic [DATA_W-1:0] val_q;
    logic              entry_fits;
    logic [REG_AW-1:0] eff_addr;

    // Whole-entry range test, one bit wider so the sum cannot wrap.
    always_comb begin
        entry_fits = ({1'b0, ptr_q} + SPAN) <= {1'b0, end_q};
        eff_addr   = (inc_q && !first_q) ? prev_addr_q + 1'b1 : addr_word_q;
    end

    // Walker state machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            state_q     <= W_IDLE;
            ptr_q       <= '0;
            end_q       <= '0;
            wr_dir_q    <= 1'b0;
            inc_q       <= 1'b0;
            first_q     <= 1'b1;
            addr_word_q <= '0;
            prev_addr_q <= '0;
            val_q       <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (start_i) begin
                    ptr_q    <= start_addr_i;
                    end_q    <= end_addr_i;
                    wr_dir_q <= wr_dir_i;
                    inc_q    <= addr_inc_i;
                    first_q  <= 1'b1;
                    state_q  <= W_CHECK;
                end
                W_CHECK:  state_q <= entry_fits ? W_REQ_A : W_IDLE;
                W_REQ_A:  if (mem_req_ready_i) state_q <= W_WAIT_A;
                W_WAIT_A: if (mem_rsp_valid_i) begin
                    addr_word_q <= mem_rsp_data_i[REG_AW-1:0];
                    state_q     <= W_REQ_V;
                end
                W_REQ_V:  if (mem_req_ready_i) state_q <= W_WAIT_V;
                W_WAIT_V: if (mem_rsp_valid_i) begin
                    val_q   <= mem_rsp_data_i;
                    state_q <= W_WRITE;
                end
                W_WRITE: begin
                    ptr_q       <= ptr_q + STEP;
                    prev_addr_q <= eff_addr;
                    first_q     <= 1'b0;
                    state_q     <= W_CHECK;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    // Port drive derived from the current state.
    always_comb begin
        mem_req_valid_o = (state_q == W_REQ_A) || (state_q == W_REQ_V);
        mem_req_addr_o  = (state_q == W_REQ_V) ? ptr_q + VAL_STEP : ptr_q;
        regw_valid_o    = (state_q == W_WRITE) && wr_dir_q;
        regw_addr_o     = eff_addr;
        regw_data_o     = val_q;
        busy_o          = (state_q != W_IDLE);
        done_set_o      = (state_q == W_CHECK) && !entry_fits && !soft_rst_i;
    end

    // R13: a stalled request holds its address.
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)))
        else $error("memory request changed while stalled");

    // R2: every read lies inside the captured inclusive range.
    p_read_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (({1'b0, mem_req_addr_o} + (MEM_AW+1)'(3)) <= {1'b0, end_q}))
        else $error("memory read outside list bounds");

    // R3: register writes are never back to back.
    p_write_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        regw_valid_o |=> !regw_valid_o)
        else $error("back-to-back register writes");

    // R8: soft reset returns the walker to idle on the next cycle.
    p_soft_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (state_q == W_IDLE && !mem_req_valid_o && !regw_valid_o))
        else $error("walker not idle after soft reset");

endmodule

// File: rtl/reglist_replay_dma.sv
// Top level of the register-list replay engine: connects the control
// registers, the event front end and the list walker. Single channel.
// Assumes the memory side honours the request/response rules stated in
// the walker header.
module reglist_replay_dma
    import rlr_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int REG_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_en,
    input  logic [2:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              regw_valid,
    output logic [REG_AW-1:0] regw_addr,
    output logic [31:0]       regw_data,
    input  logic              evt_vsync,
    input  logic              evt_line,
    output logic              irq
);

    access_cfg_t       cfg;
    trig_sel_e         sel;
    logic [MEM_AW-1:0] start_addr;
    logic [MEM_AW-1:0] end_addr;
    logic              soft_rst;
    logic              kick;
    logic              busy;
    logic              done_set;
    logic              fire;

    assign sel = cfg.sel;

    rlr_csr #(.MEM_AW(MEM_AW)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr_en  (csr_wr_en),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .done_set_i (done_set),
        .busy_i     (busy),
        .soft_rst_o (soft_rst),
        .kick_o     (kick),
        .cfg_o      (cfg),
        .start_o    (start_addr),
        .end_o      (end_addr),
        .irq_o      (irq)
    );

    rlr_trigger u_trigger (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .vsync_i (evt_vsync),
        .line_i  (evt_line),
        .kick_i  (kick),
        .busy_i  (busy),
        .fire_o  (fire)
    );

    rlr_walker #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .DATA_W(32)) u_walker (
        .clk             (clk),
        .rst_n           (rst_n),
        .soft_rst_i      (soft_rst),
        .start_i         (fire),
        .start_addr_i    (start_addr),
        .end_addr_i      (end_addr),
        .wr_dir_i        (cfg.wr_dir),
        .addr_inc_i      (cfg.addr_inc),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .regw_valid_o    (regw_valid),
        .regw_addr_o     (regw_addr),
        .regw_data_o     (regw_data),
        .busy_o          (busy),
        .done_set_o      (done_set)
    );

    // R4: a pass never starts while the select field is at stop.
    p_stop_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(sel) != TRIG_STOP))
        else $error("pass started with trigger set to stop");

endmodule

// File: tb/reglist_replay_dma_test.sv
// Self-checking bench: a behavioural memory responder, an ordered queue of
// expected register writes compared on every clock, and directed scenarios.
module reglist_replay_dma_test;

    localparam int MEM_AW = 32;
    localparam int REG_AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              csr_wr_en = 1'b0;
    logic [2:0]        csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [MEM_AW-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              regw_valid;
    logic [REG_AW-1:0] regw_addr;
    logic [31:0]       regw_data;
    logic              evt_vsync = 1'b0;
    logic              evt_line = 1'b0;
    logic              irq;

    reglist_replay_dma #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) uut (.*);

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [47:0] exp_q [$];
    int  wr_count = 0;
    int  rd_count = 0;
    logic [31:0] max_rd = '0;
    int  cyc = 0;
    bit  pend = 0;
    logic [31:0] pend_addr = '0;
    bit  prev_v = 0, prev_r = 0, prev_soft = 0;
    logic [31:0] prev_a = '0;
    bit  soft_now = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Memory responder, write monitor and handshake checker, away from posedge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && prev_v && !prev_r && !prev_soft) begin
            check(mem_req_valid && mem_req_addr == prev_a, "R13", "stalled request held",
                  mem_req_addr, prev_a);
        end
        if (rst_n && regw_valid) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                check(0, "R3", "unexpected register write", {regw_addr, regw_data}, 0);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                check({regw_addr, regw_data} == e, "R1", "ordered write addr/data",
                      {regw_addr, regw_data}, e);
            end
        end
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[pend_addr[9:2]];
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        mem_req_ready = (cyc % 3) != 0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            pend = 1;
            pend_addr = mem_req_addr;
            rd_count++;
            if (mem_req_addr > max_rd) max_rd = mem_req_addr;
        end
        prev_v = mem_req_valid;
        prev_r = mem_req_ready;
        prev_a = mem_req_addr;
        prev_soft = soft_now;
    end

    task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        soft_now  = (a == 3'd0) && d[0];
        @(negedge clk);
        csr_wr_en = 1'b0;
        soft_now  = 0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic load_list(input int base, input int n, input int tag);
        for (int i = 0; i < n; i++) begin
            mem[(base >> 2) + 2*i]     = {16'hBEEF, 16'(tag*256 + i*4 + 16)};
            mem[(base >> 2) + 2*i + 1] = 32'hC000_0000 + (tag << 16) + i;
        end
    endtask

    task automatic expect_pass(input int base, input int n, input bit inc);
        logic [15:0] first;
        first = mem[base >> 2][15:0];
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            a = inc ? 16'(first + i) : mem[(base >> 2) + 2*i][15:0];
            exp_q.push_back({a, mem[(base >> 2) + 2*i + 1]});
        end
    endtask

    task automatic wait_irq(input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1; break; end
        end
        check(seen, req, "done interrupt raised", seen, 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) evt_vsync = 1'b1; else evt_line = 1'b1;
        @(negedge clk);
        evt_vsync = 1'b0;
        evt_line  = 1'b0;
    endtask

    localparam logic [31:0] CTRL_BASE = 32'h30;  // wr burst 3, rd burst 0

    task automatic irq_clear();
        csr_write(3'd0, CTRL_BASE | 32'h2);
    endtask

    task automatic kick();
        csr_write(3'd0, CTRL_BASE | 32'h4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
        load_list(32'h100, 6, 1);
        load_list(32'h200, 6, 2);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0, "R7", "irq low after reset", irq, 0);
        csr_read(3'd4, rd);
        check(rd == 0, "R8", "status idle after reset", rd, 0);
        csr_read(3'd0, rd);
        check(rd == 32'h30, "R12", "burst fields reset values", rd, 32'h30);
        csr_write(3'd0, 32'h120);
        csr_read(3'd0, rd);
        check(rd == 32'h120, "R12", "burst fields readback", rd, 32'h120);
        csr_write(3'd0, CTRL_BASE);

        // R1/R2/R3: basic vsync pass over six entries
        csr_write(3'd1, 32'h5);
        csr_write(3'd2, 32'h100);
        csr_write(3'd3, 32'h12F);
        expect_pass(32'h100, 6, 0);
        w0 = wr_count; r0 = rd_count;
        pulse(0);
        wait_irq("R1");
        check(wr_count - w0 == 6, "R1", "writes per pass", wr_count - w0, 6);
        check(exp_q.size() == 0, "R3", "all expected writes seen", exp_q.size(), 0);
        check(rd_count - r0 == 12, "R2", "word reads per pass", rd_count - r0, 12);

        // R7: sticky until cleared
        repeat (20) @(negedge clk);
        check(irq == 1'b1, "R7", "irq held", irq, 1);
        irq_clear();
        @(negedge clk);
        check(irq == 1'b0, "R7", "irq cleared", irq, 0);

        // R5: held level and edge during pass give one pass
        expect_pass(32'h100, 6, 0);
        w0 = wr_count;
        @(negedge clk); evt_vsync = 1'b1;
        while (wr_count - w0 < 2) @(negedge clk);
        evt_vsync = 1'b0;
        @(negedge clk); evt_vsync = 1'b1;
        wait_irq("R5");
        repeat (60) @(negedge clk);
        check(wr_count - w0 == 6, "R5", "single pass for held/busy events", wr_count - w0, 6);
        evt_vsync = 1'b0;
        irq_clear();

        // R4: unselected source ignored, selected source fires
        csr_write(3'd1, 32'h6);
        w0 = wr_count;
        pulse(0);
        repeat (40) @(negedge clk);
        check(wr_count == w0 && !irq, "R4", "vsync ignored when line selected", wr_count - w0, 0);
        expect_pass(32'h100, 6, 0);
        pulse(1);
        wait_irq("R4");
        check(wr_count - w0 == 6, "R4", "line event pass", wr_count - w0, 6);
        irq_clear();

        // R4: stop blocks all sources
        csr_write(3'd1, 32'h4);
        w0 = wr_count;
        pulse(0); pulse(1); kick();
        repeat (40) @(negedge clk);
        check(wr_count == w0 && !irq, "R4", "stop blocks triggers", wr_count - w0, 0);

        // R4: manual kick
        csr_write(3'd1, 32'h7);
        expect_pass(32'h100, 6, 0);
        kick();
        wait_irq("R4");
        check(wr_count - w0 == 6, "R4", "manual kick pass", wr_count - w0, 6);
        irq_clear();

        // R6: empty range
        csr_write(3'd3, 32'h106);
        w0 = wr_count; r0 = rd_count;
        kick();
        wait_irq("R6");
        check(wr_count == w0 && rd_count == r0, "R6", "empty range no traffic",
              (wr_count - w0) + (rd_count - r0), 0);
        irq_clear();

        // R2: partial trailing entry dropped, reads bounded
        csr_write(3'd3, 32'h11D);
        expect_pass(32'h100, 3, 0);
        w0 = wr_count; max_rd = 0;
        kick();
        wait_irq("R2");
        check(wr_count - w0 == 3, "R2", "entries in partial range", wr_count - w0, 3);
        check(max_rd == 32'h114, "R2", "highest read address", max_rd, 32'h114);
        irq_clear();

        // R9: bounds changed mid-pass apply next pass
        csr_write(3'd3, 32'h12F);
        expect_pass(32'h100, 6, 0);
        w0 = wr_count;
        kick();
        while (wr_count - w0 < 1) @(negedge clk);
        csr_write(3'd3, 32'h10F);
        wait_irq("R9");
        check(wr_count - w0 == 6, "R9", "current pass uses captured end", wr_count - w0, 6);
        irq_clear();
        expect_pass(32'h100, 2, 0);
        w0 = wr_count;
        kick();
        wait_irq("R9");
        check(wr_count - w0 == 2, "R9", "next pass uses new end", wr_count - w0, 2);
        irq_clear();
        csr_write(3'd3, 32'h12F);

        // R10: address increment mode
        csr_write(3'd1, 32'hF);
        expect_pass(32'h100, 6, 1);
        w0 = wr_count;
        kick();
        wait_irq("R10");
        check(wr_count - w0 == 6 && exp_q.size() == 0, "R10", "incremented writes",
              wr_count - w0, 6);
        irq_clear();

        // R11: read direction issues no writes but completes
        csr_write(3'd1, 32'h3);
        w0 = wr_count; r0 = rd_count;
        kick();
        wait_irq("R11");
        check(wr_count == w0, "R11", "no writes in read direction", wr_count - w0, 0);
        check(rd_count - r0 == 12, "R11", "list still walked", rd_count - r0, 12);

        // R8: soft reset mid-pass (done left set from previous pass)
        csr_write(3'd1, 32'h7);
        csr_write(3'd2, 32'h200);
        csr_write(3'd3, 32'h22F);
        expect_pass(32'h200, 6, 0);
        w0 = wr_count;
        kick();
        while (wr_count - w0 < 2) @(negedge clk);
        check(irq == 1'b1, "R8", "done still set before soft reset", irq, 1);
        csr_write(3'd0, CTRL_BASE | 32'h1);
        exp_q.delete();
        csr_read(3'd4, rd);
        check(rd == 0, "R8", "status idle and done cleared", rd, 0);
        repeat (100) @(negedge clk);
        check(wr_count - w0 == 2, "R8", "no writes after soft reset", wr_count - w0, 2);
        expect_pass(32'h200, 6, 0);
        w0 = wr_count;
        kick();
        wait_irq("R8");
        check(wr_count - w0 == 6 && exp_q.size() == 0, "R8", "restart from list start",
              wr_count - w0, 6);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule